// File: doc/BRIEF.md
# Duty-Cycled Omnipolar Magnetic Switch Controller

This block is the digital core of a low-power magnetic proximity switch. A free-running counter divides time into long periods. Each period opens with a short awake window in which a sensor-enable strobe powers the analog front end. The front end then hands over a signed, already-digitised field reading, and the block takes exactly one sample of it, at the clock edge where the awake window closes.

The sample is judged against four thresholds, an operate and a release point on each side of zero. A strong enough field of either sign turns the switch on, so the output is the same for either magnet pole. Because turn-on and turn-off use different points, small vibration or noise near a threshold does not make the output chatter. The decision is held unchanged through the sleep part of the period.

The switch output is active low by default; a build parameter inverts it. A one-cycle sample-valid pulse marks each decision, so each output change can be paired with the sample that caused it.

Top module: `omni_magswitch`

## Requirements
- R1: While synchronous reset `rst` is high, the switch state is off, so `sw_out` is 1 (default polarity), `sense_en` is 1 and `sample_vld` is 0. The first cycle after reset is the first cycle of an awake window.
- R2: `sense_en` is high for exactly AWAKE_CYC cycles and then low for PERIOD_CYC - AWAKE_CYC cycles, repeating with no gaps.
- R3: `sample_vld` is high for exactly one cycle per period: the first cycle in which `sense_en` is low.
- R4: From the off state, the switch turns on when the sampled field is strictly greater than S_OPERATE or strictly less than N_OPERATE. A field equal to either point leaves it off.
- R5: From the on state, the switch turns off only when the sampled field is strictly between N_RELEASE and S_RELEASE. Otherwise it stays on.
- R6: The switch state, and so `sw_out`, changes only in a cycle where `sample_vld` is 1.
- R7: Only the field present at the last awake cycle's closing clock edge is used. Values on `field_in` in any other cycle have no effect on the output.
- R8: A zero field sampled from either state leaves the switch off.
- R9: With INV_OUT = 0, "on" drives `sw_out` to 0 and "off" to 1. With INV_OUT = 1, the levels are swapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous reset, active high |
| field_in | input | 16 | Signed field reading in units of 0.1 G, negative for a north pole |
| sense_en | output | 1 | Front-end enable strobe, high during the awake window |
| sample_vld | output | 1 | One-cycle pulse in the cycle after each decision edge |
| sw_out | output | 1 | Switch output, active low unless INV_OUT is set |

## Verification
The threshold assertions assume that `field_in` holds a defined value at the decision edge. They compare the state after the sample with the field one cycle earlier, so they rely on the field being meaningful at exactly that edge. The stimulus drives a swept value only in the last awake cycle. In every other cycle it drives a value chosen to flip the state if it were ever sampled, and it changes inputs only on falling clock edges. The sweep covers every field value across both threshold pairs, from both starting states, in a short-period configuration.

// File: rtl/omni_pkg.sv
package omni_pkg;
  localparam int FIELD_W = 16;
  typedef logic signed [FIELD_W-1:0] field_t;

  // Next switch state from the present state and one field sample.
  function automatic logic judge_next(
    input logic   on_now,
    input field_t f,
    input field_t n_op,
    input field_t n_rp,
    input field_t s_rp,
    input field_t s_op
  );
    logic trip, quiet;
    trip  = (f > s_op) || (f < n_op);
    quiet = (f < s_rp) && (f > n_rp);
    return on_now ? !quiet : trip;
  endfunction
endpackage

// File: rtl/omni_duty_timer.sv
module omni_duty_timer #(
  parameter int AWAKE_CYC  = 5625,
  parameter int PERIOD_CYC = 5625000
) (
  input  logic clk,
  input  logic rst,
  output logic sense_en,
  output logic sample_fire,
  output logic sample_vld
);
  localparam int CW = $clog2(PERIOD_CYC + 1);
  localparam logic [CW-1:0] LAST_AWAKE = CW'(AWAKE_CYC - 1);
  localparam logic [CW-1:0] LAST_CYC   = CW'(PERIOD_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      cnt_q <= (cnt_q == LAST_CYC) ? '0 : cnt_q + 1'b1;
      vld_q <= sample_fire;
    end
  end

  assign sense_en    = (cnt_q <= LAST_AWAKE);
  assign sample_fire = (cnt_q == LAST_AWAKE);
  assign sample_vld  = vld_q;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (sense_en && !sample_vld));
  // R2
  strobe_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sense_en) |-> sample_vld);
  // R3
  vld_single_chk: assert property (@(posedge clk) disable iff (rst)
    sample_vld |=> !sample_vld);
  // R3
  vld_sleep_chk: assert property (@(posedge clk) disable iff (rst)
    sample_vld |-> !sense_en);
endmodule

// File: rtl/omni_hyst_judge.sv
module omni_hyst_judge
  import omni_pkg::*;
#(
  parameter field_t N_OPERATE = -16'sd400,
  parameter field_t N_RELEASE = -16'sd340,
  parameter field_t S_RELEASE = 16'sd310,
  parameter field_t S_OPERATE = 16'sd370
) (
  input  logic   clk,
  input  logic   rst,
  input  field_t field_in,
  input  logic   sample_fire,
  input  logic   sample_vld,
  output logic   on_q
);
  logic on_next;

  always_comb
    on_next = judge_next(on_q, field_in, N_OPERATE, N_RELEASE, S_RELEASE, S_OPERATE);

  always_ff @(posedge clk) begin
    if (rst)              on_q <= 1'b0;
    else if (sample_fire) on_q <= on_next;
  end

  // R6
  hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(on_q) |-> sample_vld);
  // R4
  turn_on_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_vld && !$past(on_q) &&
     (($past(field_in) > S_OPERATE) || ($past(field_in) < N_OPERATE))) |-> on_q);
  // R4
  stay_off_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_vld && !$past(on_q) &&
     ($past(field_in) <= S_OPERATE) && ($past(field_in) >= N_OPERATE)) |-> !on_q);
  // R5
  turn_off_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_vld && $past(on_q) &&
     ($past(field_in) < S_RELEASE) && ($past(field_in) > N_RELEASE)) |-> !on_q);
endmodule

// File: rtl/omni_out_drive.sv
module omni_out_drive #(
  parameter bit INV_OUT = 1'b0
) (
  input  logic on_q,
  output logic sw_out
);
  generate
    if (INV_OUT) begin : g_active_high
      assign sw_out = on_q;
    end else begin : g_active_low
      assign sw_out = !on_q;
    end
  endgenerate
endmodule

// File: rtl/omni_magswitch.sv
module omni_magswitch
  import omni_pkg::*;
#(
  parameter int     AWAKE_CYC  = 5625,
  parameter int     PERIOD_CYC = 5625000,
  parameter field_t N_OPERATE  = -16'sd400,
  parameter field_t N_RELEASE  = -16'sd340,
  parameter field_t S_RELEASE  = 16'sd310,
  parameter field_t S_OPERATE  = 16'sd370,
  parameter bit     INV_OUT    = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic signed [FIELD_W-1:0] field_in,
  output logic                      sense_en,
  output logic                      sample_vld,
  output logic                      sw_out
);
  generate
    if (!((N_OPERATE < N_RELEASE) && (N_RELEASE < S_RELEASE) && (S_RELEASE < S_OPERATE)))
    begin : g_bad_thresholds
      $error("omni_magswitch: thresholds must be strictly increasing north-operate to south-operate");
    end
    if (!((AWAKE_CYC >= 1) && (AWAKE_CYC < PERIOD_CYC - 1))) begin : g_bad_timing
      $error("omni_magswitch: awake window must be shorter than the period");
    end
  endgenerate

  logic sample_fire;
  logic on_q;

  omni_duty_timer #(
    .AWAKE_CYC (AWAKE_CYC),
    .PERIOD_CYC(PERIOD_CYC)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .sense_en   (sense_en),
    .sample_fire(sample_fire),
    .sample_vld (sample_vld)
  );

  omni_hyst_judge #(
    .N_OPERATE(N_OPERATE),
    .N_RELEASE(N_RELEASE),
    .S_RELEASE(S_RELEASE),
    .S_OPERATE(S_OPERATE)
  ) u_judge (
    .clk        (clk),
    .rst        (rst),
    .field_in   (field_in),
    .sample_fire(sample_fire),
    .sample_vld (sample_vld),
    .on_q       (on_q)
  );

  omni_out_drive #(
    .INV_OUT(INV_OUT)
  ) u_drive (
    .on_q  (on_q),
    .sw_out(sw_out)
  );
endmodule

// File: tb/omni_magswitch_test.sv
module omni_magswitch_test;
  localparam int AW  = 4;
  localparam int PER = 16;
  localparam logic signed [15:0] NOP = -16'sd400;
  localparam logic signed [15:0] NRP = -16'sd340;
  localparam logic signed [15:0] SRP = 16'sd310;
  localparam logic signed [15:0] SOP = 16'sd370;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [15:0] field = '0;
  logic en_a, vld_a, out_a, en_b, vld_b, out_b;
  int   tests = 0;
  int   fails = 0;
  logic ref_on = 1'b0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  omni_magswitch #(.AWAKE_CYC(AW), .PERIOD_CYC(PER), .N_OPERATE(NOP), .N_RELEASE(NRP),
    .S_RELEASE(SRP), .S_OPERATE(SOP), .INV_OUT(1'b0)) uut (
    .clk(clk), .rst(rst), .field_in(field), .sense_en(en_a), .sample_vld(vld_a), .sw_out(out_a));

  omni_magswitch #(.AWAKE_CYC(AW), .PERIOD_CYC(PER), .N_OPERATE(NOP), .N_RELEASE(NRP),
    .S_RELEASE(SRP), .S_OPERATE(SOP), .INV_OUT(1'b1)) uut_inv (
    .clk(clk), .rst(rst), .field_in(field), .sense_en(en_b), .sample_vld(vld_b), .sw_out(out_b));

  task automatic check(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: on if the magnitude lies beyond the relevant point on that side.
  function automatic logic model(input logic cur, input logic signed [15:0] f);
    if (f >= 0) return cur ? (f >= SRP) : (f > SOP);
    else        return cur ? (f <= NRP) : (f < NOP);
  endfunction

  // One full period, starting at the negedge of cycle 0. fv is presented only
  // in the last awake cycle; noise everywhere else.
  task automatic run_period(input logic signed [15:0] fv, input logic signed [15:0] noise,
                            input string tag);
    for (int c = 0; c < PER; c++) begin
      check("R2 sense_en", en_a, (c < AW));
      check("R3 sample_vld", vld_a, (c == AW));
      if (c == AW) ref_on = model(ref_on, fv);
      check(tag, out_a, !ref_on);
      check("R9 inverted output", out_b, ref_on);
      field = (c == AW - 1) ? fv : noise;
      @(negedge clk);
    end
  endtask

  // Noise that would flip the present state if it were sampled: R7
  function automatic logic signed [15:0] flip_noise();
    return ref_on ? 16'sd0 : 16'sd1000;
  endfunction

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset sw_out", out_a, 1'b1);
    check("R1 reset sense_en", en_a, 1'b1);
    check("R1 reset sample_vld", vld_a, 1'b0);
    check("R9 reset inverted", out_b, 1'b0);
    rst = 1'b0;
    // R8: zero field from off stays off
    run_period(16'sd0, 16'sd1000, "R8 zero from off");
    // R8: zero field from on turns off
    run_period(16'sd500, flip_noise(), "R4 force on");
    run_period(16'sd0, flip_noise(), "R8 zero from on");
    // R4 / R5 sweep from both start states, every value across both threshold pairs
    for (int s = 0; s < 2; s++) begin
      for (int v = -420; v <= 420; v++) begin
        run_period((s == 1) ? 16'sd500 : -16'sd5, flip_noise(), "R6 set start state");
        run_period(16'(v), flip_noise(), (s == 1) ? "R5 release from on" : "R4 operate from off");
      end
    end
    // R7: last period with north-side noise against an on state
    run_period(-16'sd500, flip_noise(), "R4 north operate");
    run_period(-16'sd500, 16'sd0, "R7 noise ignored");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule